// File: doc/BRIEF.md
# Secure Per-CPU Interrupt Front End

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its best pending candidate, with the candidate's ID, 8-bit priority and security class. The block decides whether that candidate may interrupt the processor. The candidate must belong to an enabled class, its priority must lie under the priority mask, and it must beat the priority of the interrupt already being serviced. A candidate that qualifies is driven onto the IRQ or the FIQ line.

The processor acknowledges to claim the interrupt and writes end-of-interrupt when it is done. Priorities of interrupts in service are kept on a small stack. The top of the stack is the running priority, which reads 0xFF when nothing is in service. A secure acknowledge of a non-secure candidate can be refused with a sentinel ID, so that the candidate stays pending at the distributor.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, `irq`, `fiq`, `ack_vld` and `cand_taken` are 0 and `running_prio` reads 0xFF.
- R2: A candidate is signalled only when its priority is strictly less than `pmask`. A mask of 0 blocks everything.
- R3: A candidate whose class enable is clear is never signalled. `cand_ns`=1 selects the non-secure class with enable `en_ns`; `cand_ns`=0 selects the secure class with enable `en_s`. An acknowledge of such a candidate returns 1023.
- R4: A signalled secure candidate drives `fiq` when `fiq_sec`=1 and `irq` when `fiq_sec`=0. A non-secure candidate always drives `irq`. `irq` and `fiq` are registered and follow the inputs one clock later.
- R5: The group priority is the priority with its low `bp` bits cleared, where `bp` is 0 to 7. While an interrupt is in service, a candidate preempts only if its group priority is strictly below the group priority of `running_prio`, both computed with the candidate's binary point. When nothing is in service, any candidate passes this check.
- R6: Secure candidates use `bpr_s`. Non-secure candidates use `bpr_ns` when `share_bpr`=0 and `bpr_s` when `share_bpr`=1.
- R7: The clock after `ack_req`, `ack_vld` pulses for one cycle with `ack_id`. For a granted candidate, `ack_id` is the candidate ID, `cand_taken` pulses and `running_prio` becomes the candidate's priority.
- R8: A secure acknowledge (`ack_secure`=1) of a signalled non-secure candidate returns 1022 when `ack_ns_ok`=0. In that case there is no `cand_taken` and `running_prio` is unchanged. When `ack_ns_ok`=1, it returns the candidate ID and takes the candidate.
- R9: An acknowledge with no qualifying candidate returns 1023, with no `cand_taken` and no stack change.
- R10: `eoi_req` pops the stack. `running_prio` returns to the previous level, or to 0xFF when the stack is empty.
- R11: A non-secure acknowledge (`ack_secure`=0) of a secure candidate returns 1023 and takes nothing.
- R12: When `ack_req` and `eoi_req` are high in the same cycle, only the end-of-interrupt acts. No `ack_vld` follows.
- R13: When the stack holds DEPTH entries, no candidate is signalled and an acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor presents a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower value is more urgent) |
| cand_ns | input | 1 | 1 = non-secure candidate |
| en_s | input | 1 | Secure class forwarding enable |
| en_ns | input | 1 | Non-secure class forwarding enable |
| pmask | input | 8 | Priority mask |
| bpr_s | input | 3 | Secure binary point |
| bpr_ns | input | 3 | Non-secure binary point |
| share_bpr | input | 1 | Use `bpr_s` for both classes |
| fiq_sec | input | 1 | Route secure candidates to FIQ |
| ack_ns_ok | input | 1 | Secure acknowledge may claim non-secure candidates |
| ack_req | input | 1 | Acknowledge access strobe |
| ack_secure | input | 1 | Acknowledge comes from the secure side |
| eoi_req | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Normal interrupt line |
| fiq | output | 1 | Fast interrupt line |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledge response ID |
| cand_taken | output | 1 | Candidate claimed; the distributor clears its pending state |
| running_prio | output | 8 | Priority of the interrupt in service, 0xFF when idle |

## Verification
A table of candidates is applied with nothing in service. It varies class, priority against mask, enables and FIQ routing, and separates the strict mask compare from an off-by-one. It also tells which class each enable gates and which line each class drives. With one interrupt in service, the same candidate priority is tried under several binary points and under the shared-binary-point flag. This shows whether grouping masks the correct bits and which binary point each class uses. Acknowledge sequences then cover the 1022 and 1023 outcomes, eight-deep nesting to a full stack, and unwinding through end-of-interrupt.

// File: rtl/cii_pkg.sv
package cii_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam int BP_W   = 3;

  localparam logic [PRIO_W-1:0] PRIO_IDLE  = '1;
  localparam logic [ID_W-1:0]   ID_NS_HELD = 10'd1022;
  localparam logic [ID_W-1:0]   ID_NONE    = 10'd1023;

  // group priority: low bp bits cleared
  function automatic logic [PRIO_W-1:0] grp_of(input logic [PRIO_W-1:0] p,
                                               input logic [BP_W-1:0]   bp);
    return p & (PRIO_IDLE << bp);
  endfunction
endpackage

// File: rtl/cii_prio_stack.sv
module cii_prio_stack
  import cii_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign top_idx = cnt - CW'(1);
  assign top_prio = empty ? PRIO_IDLE : mem[top_idx[PW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PW-1:0]] <= push_prio;
  end
endmodule

// File: rtl/cii_select.sv
module cii_select
  import cii_pkg::*;
(
  input  logic              cand_valid,
  input  logic              cand_ns,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              en_s,
  input  logic              en_ns,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [BP_W-1:0]   bpr_s,
  input  logic [BP_W-1:0]   bpr_ns,
  input  logic              share_bpr,
  input  logic              fiq_sec,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stk_empty,
  input  logic              stk_full,
  output logic              class_on,
  output logic              under_mask,
  output logic              preempts,
  output logic              eligible,
  output logic              to_fiq
);
  logic [BP_W-1:0] bp_use;

  always_comb begin
    bp_use     = (cand_ns && !share_bpr) ? bpr_ns : bpr_s;
    class_on   = cand_ns ? en_ns : en_s;
    under_mask = cand_prio < pmask;
    preempts   = stk_empty ||
                 (grp_of(cand_prio, bp_use) < grp_of(run_prio, bp_use));
    eligible   = cand_valid && class_on && under_mask && preempts && !stk_full;
    to_fiq     = !cand_ns && fiq_sec;
  end
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cii_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_ns,
  input  logic              en_s,
  input  logic              en_ns,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [BP_W-1:0]   bpr_s,
  input  logic [BP_W-1:0]   bpr_ns,
  input  logic              share_bpr,
  input  logic              fiq_sec,
  input  logic              ack_ns_ok,
  input  logic              ack_req,
  input  logic              ack_secure,
  input  logic              eoi_req,
  output logic              irq,
  output logic              fiq,
  output logic              ack_vld,
  output logic [ID_W-1:0]   ack_id,
  output logic              cand_taken,
  output logic [PRIO_W-1:0] running_prio
);
  logic stk_empty, stk_full;
  logic class_on, under_mask, preempts, eligible, to_fiq;
  logic ack_go, grant, push_ev, pop_ev;
  logic [ID_W-1:0] resp_id;

  cii_prio_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pop(pop_ev),
    .push_prio(cand_prio), .top_prio(running_prio),
    .empty(stk_empty), .full(stk_full)
  );

  cii_select u_sel (
    .cand_valid(cand_valid), .cand_ns(cand_ns), .cand_prio(cand_prio),
    .en_s(en_s), .en_ns(en_ns), .pmask(pmask), .bpr_s(bpr_s),
    .bpr_ns(bpr_ns), .share_bpr(share_bpr), .fiq_sec(fiq_sec),
    .run_prio(running_prio), .stk_empty(stk_empty), .stk_full(stk_full),
    .class_on(class_on), .under_mask(under_mask), .preempts(preempts),
    .eligible(eligible), .to_fiq(to_fiq)
  );

  // end-of-interrupt wins over a simultaneous acknowledge
  assign ack_go = ack_req && !eoi_req;
  assign pop_ev = eoi_req;

  always_comb begin
    grant   = 1'b0;
    resp_id = ID_NONE;
    if (eligible) begin
      if (ack_secure && cand_ns && !ack_ns_ok) begin
        resp_id = ID_NS_HELD;
      end else if (!ack_secure && !cand_ns) begin
        resp_id = ID_NONE;
      end else begin
        grant   = 1'b1;
        resp_id = cand_id;
      end
    end
  end

  assign push_ev = ack_go && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      fiq        <= 1'b0;
      ack_vld    <= 1'b0;
      ack_id     <= ID_NONE;
      cand_taken <= 1'b0;
    end else begin
      irq        <= eligible && !to_fiq;
      fiq        <= eligible && to_fiq;
      ack_vld    <= ack_go;
      cand_taken <= push_ev;
      if (ack_go) ack_id <= resp_id;
    end
  end
endmodule

// File: rtl/cpu_irq_iface_chk.sv
module cpu_irq_iface_chk
  import cii_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cand_valid,
  input logic              cand_ns,
  input logic [PRIO_W-1:0] cand_prio,
  input logic [PRIO_W-1:0] pmask,
  input logic              en_s,
  input logic              en_ns,
  input logic              fiq_sec,
  input logic              eoi_req,
  input logic              irq,
  input logic              fiq,
  input logic              ack_vld,
  input logic [ID_W-1:0]   ack_id,
  input logic              cand_taken,
  input logic [PRIO_W-1:0] running_prio
);
  a_r2_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> $past(cand_valid && (cand_prio < pmask)));

  a_r3_class_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> $past(cand_ns ? en_ns : en_s));

  a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, fiq}));

  a_r4_fiq_route: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> $past(!cand_ns && fiq_sec));

  a_r7_push_prio: assert property (@(posedge clk) disable iff (!rst_n)
    cand_taken |-> (running_prio == $past(cand_prio)));

  a_r8_held_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_id == ID_NS_HELD) |-> !cand_taken);

  a_r12_eoi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(!eoi_req));
endmodule

bind cpu_irq_iface cpu_irq_iface_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ns(cand_ns),
  .cand_prio(cand_prio), .pmask(pmask), .en_s(en_s), .en_ns(en_ns),
  .fiq_sec(fiq_sec), .eoi_req(eoi_req), .irq(irq), .fiq(fiq),
  .ack_vld(ack_vld), .ack_id(ack_id), .cand_taken(cand_taken),
  .running_prio(running_prio)
);

// File: tb/cpu_irq_iface_test.sv
`timescale 1ns/1ps
module cpu_irq_iface_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cand_valid, cand_ns, en_s, en_ns, share_bpr, fiq_sec;
  logic       ack_ns_ok, ack_req, ack_secure, eoi_req;
  logic [9:0] cand_id;
  logic [7:0] cand_prio, pmask;
  logic [2:0] bpr_s, bpr_ns;
  logic       irq, fiq, ack_vld, cand_taken;
  logic [9:0] ack_id;
  logic [7:0] running_prio;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cpu_irq_iface #(.DEPTH(8)) uut (.*);

  // {ns, prio, pmask, en_s, en_ns, fiq_sec, exp_irq, exp_fiq}
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'h40, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h40, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b1, 8'h40, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h7F, 8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h10, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h10, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack(input logic sec);
    @(negedge clk);
    ack_secure = sec;
    ack_req    = 1'b1;
    @(negedge clk);
    ack_req    = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk);
    eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
  endtask

  task automatic set_cand(input logic ns, input logic [7:0] p,
                          input logic [9:0] id);
    cand_valid = 1'b1;
    cand_ns    = ns;
    cand_prio  = p;
    cand_id    = id;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cand_valid = 0; cand_ns = 0; en_s = 1; en_ns = 1; share_bpr = 0;
    fiq_sec = 0; ack_ns_ok = 0; ack_req = 0; ack_secure = 1; eoi_req = 0;
    cand_id = 0; cand_prio = 8'hFF; pmask = 8'hFF; bpr_s = 0; bpr_ns = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 fiq", fiq, 0);
    check("R1 ack_vld", ack_vld, 0);
    check("R1 cand_taken", cand_taken, 0);
    check("R1 running_prio", running_prio, 8'hFF);

    // R2 R3 R4 vector table, nothing in service
    for (int i = 0; i < NV; i++) begin
      set_cand(VEC[i][21], VEC[i][20:13], 10'd40 + 10'(i));
      pmask   = VEC[i][12:5];
      en_s    = VEC[i][4];
      en_ns   = VEC[i][3];
      fiq_sec = VEC[i][2];
      settle();
      check($sformatf("R2/R3/R4 vec%0d irq", i), irq, VEC[i][1]);
      check($sformatf("R2/R3/R4 vec%0d fiq", i), fiq, VEC[i][0]);
    end

    // R3 ack of disabled class returns 1023
    set_cand(1'b0, 8'h10, 10'd5); en_s = 0; en_ns = 1; pmask = 8'hFF;
    do_ack(1'b1);
    check("R3 ack id disabled", ack_id, 10'd1023);
    check("R3 not taken", cand_taken, 0);
    en_s = 1; fiq_sec = 0;

    // R7 grant secure candidate
    set_cand(1'b0, 8'h60, 10'd37);
    do_ack(1'b1);
    check("R7 ack_vld", ack_vld, 1);
    check("R7 ack_id", ack_id, 10'd37);
    check("R7 taken", cand_taken, 1);
    check("R7 running", running_prio, 8'h60);
    @(negedge clk);
    check("R7 ack_vld one cycle", ack_vld, 0);

    // R5 binary point grouping against running 0x60
    set_cand(1'b0, 8'h58, 10'd38); bpr_s = 3'd3;
    settle();
    check("R5 bp3 preempts", irq, 1);
    bpr_s = 3'd6;
    settle();
    check("R5 bp6 same group", irq, 0);
    set_cand(1'b0, 8'h60, 10'd38); bpr_s = 3'd0;
    settle();
    check("R5 equal prio no preempt", irq, 0);

    // R6 shared binary point for non-secure candidate
    set_cand(1'b1, 8'h58, 10'd39); bpr_ns = 3'd0; bpr_s = 3'd6; share_bpr = 0;
    settle();
    check("R6 own bp", irq, 1);
    share_bpr = 1;
    settle();
    check("R6 shared bp", irq, 0);
    share_bpr = 0; bpr_s = 0;

    // R10 pop back to idle
    do_eoi();
    check("R10 idle after eoi", running_prio, 8'hFF);

    // R8 secure ack of non-secure candidate
    set_cand(1'b1, 8'h30, 10'd77); ack_ns_ok = 0;
    settle();
    do_ack(1'b1);
    check("R8 held id", ack_id, 10'd1022);
    check("R8 held not taken", cand_taken, 0);
    check("R8 running unchanged", running_prio, 8'hFF);
    ack_ns_ok = 1;
    do_ack(1'b1);
    check("R8 allowed id", ack_id, 10'd77);
    check("R8 allowed taken", cand_taken, 1);
    check("R8 running", running_prio, 8'h30);
    ack_ns_ok = 0;

    // R12 ack and eoi together: only eoi acts
    set_cand(1'b1, 8'h10, 10'd78);
    @(negedge clk);
    ack_secure = 1'b0; ack_req = 1'b1; eoi_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0; eoi_req = 1'b0;
    check("R12 no ack_vld", ack_vld, 0);
    check("R12 eoi popped", running_prio, 8'hFF);

    // R9 nothing valid
    cand_valid = 1'b0;
    do_ack(1'b1);
    check("R9 spurious id", ack_id, 10'd1023);
    check("R9 not taken", cand_taken, 0);
    check("R9 running", running_prio, 8'hFF);

    // R11 non-secure ack of secure candidate
    set_cand(1'b0, 8'h20, 10'd90);
    do_ack(1'b0);
    check("R11 id", ack_id, 10'd1023);
    check("R11 not taken", cand_taken, 0);

    // R13 fill the stack
    for (int k = 0; k < 8; k++) begin
      set_cand(1'b0, 8'h80 - 8'(k * 16), 10'd100 + 10'(k));
      do_ack(1'b1);
      check($sformatf("R13 nest %0d id", k), ack_id, 10'd100 + 10'(k));
    end
    check("R13 running deepest", running_prio, 8'h10);
    set_cand(1'b0, 8'h08, 10'd200);
    settle();
    check("R13 full no irq", irq, 0);
    do_ack(1'b1);
    check("R13 full ack id", ack_id, 10'd1023);
    check("R13 full not taken", cand_taken, 0);
    cand_valid = 1'b0;

    // R10 unwind
    for (int k = 7; k >= 1; k--) begin
      do_eoi();
      check($sformatf("R10 unwind %0d", k), running_prio, 8'h80 - 8'((k - 1) * 16));
    end
    do_eoi();
    check("R10 unwind idle", running_prio, 8'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule